// File: doc/BRIEF.md
# Double-Pumped Register File for Dual Issue

This block is the architectural register file of a pipeline that decodes two instructions per cycle. Each core cycle it delivers four source operands, two per instruction, and commits two write-back results, one per instruction stream. It gets these six accesses per cycle out of dual-port synchronous storage by running that storage on a second clock. This fast clock runs at twice the core rate and is phase-locked to it, so every core cycle contains two fast edges.

The first fast edge of a core cycle falls in the middle of the cycle. On that edge both physical ports of every storage bank write. The second fast edge coincides with the next core edge. On that edge both ports of every bank read. The banks are identical copies: each one takes both write-backs, and each serves two of the four read lanes. The read registers of the banks are the block's output registers. They load only on edges that line up with the core clock, so core logic sees plain registered outputs.

A read therefore sees every write issued in the same core cycle. When both write ports target the same register, the second stream's data is kept. Register zero always reads as zero.

Top module: `dual_issue_regfile`

## Requirements
- R1: Read data for all four lanes, addressed in core cycle k, appears on `rd_data` just after the core edge that closes cycle k and holds for the whole of cycle k+1.
- R2: Two enabled writes to different registers in one core cycle are both committed, and later reads return each one.
- R3: When both write ports are enabled with the same nonzero address in one core cycle, the register takes the data of write port 1.
- R4: A read in the same core cycle as a write to that register returns the newly written data.
- R5: Reads of register 0 return zero, and writes addressed to register 0 leave it reading zero.
- R6: A write port whose enable is low does not change any register, whatever its address and data.
- R7: While `rst` is high, every lane of `rd_data` is zero.
- R8: `rd_data` does not change at the mid-cycle fast edge. It changes only at fast edges that coincide with core edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| clk2x | input | 1 | Fast clock, twice the core rate, rising edges aligned with `clk` |
| rst | input | 1 | Synchronous active-high reset, released between a core edge and the next mid-cycle fast edge |
| rd_addr | input | 4 x 5 | Read addresses; lanes 0 and 1 belong to instruction 0, lanes 2 and 3 to instruction 1 |
| rd_data | output | 4 x 32 | Registered read data, one lane per address |
| wr_en | input | 2 | Write enables; index 0 is the first stream, index 1 the second |
| wr_addr | input | 2 x 5 | Write addresses |
| wr_data | input | 2 x 32 | Write data |

## Verification
Every operand is due exactly one core cycle after its address is presented. In that same cycle the operand already reflects the writes issued alongside it. The bench drives inputs 1 ns after a core edge and records the expected operands at that moment. It compares them 1 ns after the following core edge. It samples the outputs again just after the mid-cycle fast edge and requires them unchanged, because the only register between address and data is the bank read register on the aligned fast edge.

// File: rtl/dirf_pkg.sv
package dirf_pkg;

  typedef enum logic {
    PH_WRITE = 1'b0,
    PH_READ  = 1'b1
  } fast_phase_e;

  // A write is real only outside reset, when enabled, and not to register 0.
  function automatic logic wr_effective(input logic en, input int unsigned addr,
                                        input logic in_reset);
    return en && (addr != 0) && !in_reset;
  endfunction

  // Port 0 yields to port 1 when both hit the same register.
  function automatic logic port0_survives(input logic en0, input int unsigned a0,
                                          input logic en1, input int unsigned a1);
    return !(en0 && en1 && (a0 == a1));
  endfunction

endpackage

// File: rtl/dirf_phase.sv
module dirf_phase
  import dirf_pkg::*;
(
  input  logic        clk2x,
  input  logic        rst,
  output fast_phase_e phase
);

  // After reset release the first fast edge is mid-cycle (write), the next
  // coincides with the core edge (read).
  always_ff @(posedge clk2x) begin
    if (rst) phase <= PH_WRITE;
    else     phase <= (phase == PH_WRITE) ? PH_READ : PH_WRITE;
  end

endmodule

// File: rtl/dirf_bank.sv
module dirf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk2x,
  input  logic          rst,
  input  logic          wr_slot,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rq0,
  output logic [DW-1:0] rq1
);

  logic [DW-1:0] mem [DEPTH];

  // Write slot: both physical ports write.
  always_ff @(posedge clk2x) begin
    if (wr_slot) begin
      if (we0) mem[wa0] <= wd0;
      if (we1) mem[wa1] <= wd1;
    end
  end

  // Read slot: both physical ports read into the output registers.
  always_ff @(posedge clk2x) begin
    if (rst) begin
      rq0 <= '0;
      rq1 <= '0;
    end else if (!wr_slot) begin
      rq0 <= (ra0 == '0) ? '0 : mem[ra0];
      rq1 <= (ra1 == '0) ? '0 : mem[ra1];
    end
  end

  // R3: a committed port-1 write is present after its write slot.
  p_port1_lands_r3: assert property (@(posedge clk2x) disable iff (rst)
    (wr_slot && we1) |=> (mem[$past(wa1)] == $past(wd1)));

  // R5: register 0 storage is never touched.
  p_zero_untouched_r5: assert property (@(posedge clk2x) disable iff (rst)
    $stable(mem[0]));

endmodule

// File: rtl/dual_issue_regfile.sv
module dual_issue_regfile
  import dirf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREGS  = 32,
  parameter int NBANKS = 2,
  localparam int AW    = $clog2(NREGS),
  localparam int NRD   = 2 * NBANKS
) (
  input  logic                    clk,
  input  logic                    clk2x,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  input  logic [1:0]              wr_en,
  input  logic [1:0][AW-1:0]      wr_addr,
  input  logic [1:0][DW-1:0]      wr_data
);

  fast_phase_e phase;
  logic        wr_slot;
  logic [1:0]  wr_commit;
  logic        ev_same_target;

  dirf_phase u_phase (
    .clk2x (clk2x),
    .rst   (rst),
    .phase (phase)
  );

  assign wr_slot        = (phase == PH_WRITE);
  assign ev_same_target = !port0_survives(wr_en[0], int'(wr_addr[0]),
                                          wr_en[1], int'(wr_addr[1]));
  assign wr_commit[1]   = wr_effective(wr_en[1], int'(wr_addr[1]), rst);
  assign wr_commit[0]   = wr_effective(wr_en[0], int'(wr_addr[0]), rst)
                          && !ev_same_target;

  // Each bank holds a full copy and serves two read lanes.
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    dirf_bank #(.DW(DW), .DEPTH(NREGS)) u_bank (
      .clk2x   (clk2x),
      .rst     (rst),
      .wr_slot (wr_slot),
      .we0     (wr_commit[0]),
      .wa0     (wr_addr[0]),
      .wd0     (wr_data[0]),
      .we1     (wr_commit[1]),
      .wa1     (wr_addr[1]),
      .wd1     (wr_data[1]),
      .ra0     (rd_addr[2*b]),
      .ra1     (rd_addr[2*b+1]),
      .rq0     (rd_data[2*b]),
      .rq1     (rd_data[2*b+1])
    );
  end

  // R8: at each core edge the fast domain is in its read slot.
  p_read_slot_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ));

  for (genvar r = 0; r < NRD; r++) begin : g_rd_chk
    // R5: register 0 reads zero one core cycle later.
    p_zero_reads_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_addr[r]) == '0) |-> (rd_data[r] == '0));
    // R4: same-cycle write from stream 1 is visible to the read.
    p_fresh_read_r4: assert property (@(posedge clk) disable iff (rst)
      $past(wr_commit[1] && (rd_addr[r] == wr_addr[1]))
        |-> (rd_data[r] == $past(wr_data[1])));
  end

endmodule

// File: tb/sim_dual_issue_regfile.sv
`timescale 1ns/100ps
module sim_dual_issue_regfile;

  logic              clk = 1'b0;
  logic              clk2x = 1'b1;
  logic              rst = 1'b1;
  logic [3:0][4:0]   rd_addr = '0;
  logic [3:0][31:0]  rd_data;
  logic [1:0]        wr_en = '0;
  logic [1:0][4:0]   wr_addr = '0;
  logic [1:0][31:0]  wr_data = '0;

  always #5   clk   = ~clk;
  always #2.5 clk2x = ~clk2x;

  dual_issue_regfile u0 (
    .clk(clk), .clk2x(clk2x), .rst(rst),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned model [32];
  logic [31:0] exp_d [4];
  string       exp_t [4];
  bit          exp_v = 1'b0;
  bit          done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One core cycle: check last cycle's reads, drive new inputs, then
  // confirm the outputs hold across the mid-cycle fast edge.
  task automatic cycle(input bit cls, input string tag,
                       input logic [1:0] we, input logic [1:0][4:0] wa,
                       input logic [1:0][31:0] wd, input logic [3:0][4:0] ra);
    logic [3:0][31:0] held;
    @(posedge clk);
    #1;
    if (exp_v)
      for (int i = 0; i < 4; i++) check(exp_t[i], rd_data[i], exp_d[i]);
    held = rd_data;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    for (int p = 0; p < 2; p++)
      if (we[p] && wa[p] != 0) model[wa[p]] = wd[p];
    for (int i = 0; i < 4; i++) begin
      exp_d[i] = (ra[i] == 0) ? 32'd0 : model[ra[i]];
      if (!cls) exp_t[i] = tag;
      else if (ra[i] == 0) exp_t[i] = "R5";
      else if (we == 2'b11 && wa[0] == ra[i] && wa[1] == ra[i]) exp_t[i] = "R3";
      else if ((we[0] && wa[0] == ra[i]) || (we[1] && wa[1] == ra[i])) exp_t[i] = "R4";
      else exp_t[i] = "R1";
    end
    exp_v = 1'b1;
    #5;
    for (int i = 0; i < 4; i++) check("R8", rd_data[i], held[i]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) check("R7", rd_data[i], 32'd0);
    rst = 1'b0;
    // R2: fill registers 1..31 two per cycle; read register 0 meanwhile.
    for (int a = 0; a < 32; a += 2)
      cycle(0, "R5", 2'b11, {5'(a + 1), 5'(a)},
            {32'hA000_0000 + 32'(a + 1), 32'hB000_0000 + 32'(a)}, '0);
    // R1/R2: read everything back, four lanes per cycle.
    for (int a = 0; a < 32; a += 4)
      cycle(0, "R2", 2'b00, '0, '0, {5'(a + 3), 5'(a + 2), 5'(a + 1), 5'(a)});
    // R3: both ports to register 9, read in same cycle and again later.
    cycle(0, "R3", 2'b11, {5'd9, 5'd9}, {32'h1111_1111, 32'h2222_2222},
          {5'd9, 5'd9, 5'd9, 5'd9});
    cycle(0, "R3", 2'b00, '0, '0, {5'd9, 5'd9, 5'd9, 5'd9});
    // R4: write 12 and 13, read them in the same cycle.
    cycle(0, "R4", 2'b11, {5'd13, 5'd12}, {32'hCAFE_0013, 32'hBEEF_0012},
          {5'd13, 5'd12, 5'd13, 5'd12});
    // R5: writes aimed at register 0.
    cycle(0, "R5", 2'b11, {5'd0, 5'd0}, {32'hFFFF_FFFF, 32'h1234_5678}, '0);
    cycle(0, "R5", 2'b00, '0, '0, '0);
    // R6: disabled writes with live address and data.
    cycle(0, "R6", 2'b00, {5'd7, 5'd5}, {32'hDEAD_DEAD, 32'hDEAD_BEEF},
          {5'd7, 5'd5, 5'd7, 5'd5});
    cycle(0, "R6", 2'b00, '0, '0, {5'd7, 5'd5, 5'd7, 5'd5});
    // R1: random traffic, tags chosen per lane.
    for (int n = 0; n < 400; n++)
      cycle(1, "R1", 2'($urandom), {5'($urandom), 5'($urandom % 8)},
            {32'($urandom), 32'($urandom)},
            {5'($urandom), 5'($urandom % 8), 5'($urandom), 5'($urandom % 8)});
    cycle(0, "R1", 2'b00, '0, '0, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule